// File: doc/BRIEF.md
# Register Rename Table with Tag Pool

This block maps architectural register names to physical register tags for an out-of-order core. It handles one instruction per cycle. Each request carries two source names and, optionally, one destination name. In the same cycle, the block returns four tags:

- the current physical tag for each source,
- a fresh tag for the destination, taken from a pool of unused tags,
- the tag the destination was bound to until now.

A later retirement stage can hand that old tag back. It does so through a separate release port, and the tag joins the back of the pool. Because each write gets its own physical tag, write-after-read and write-after-write conflicts disappear. Read-after-write links remain visible as matching tags.

Sources are resolved against the table as it stands before the instruction's own destination is rebound. The pool is a strict first-in first-out queue. After reset, name `i` is bound to tag `i`. The pool must then be loaded with tags `NUM_ARCH` to `NUM_PHYS-1`. A small controller with two states does this:

- `RN_FILL` (entered on reset): pushes one initial tag per cycle.
- `RN_RUN`: entered from `RN_FILL` when the last initial tag has been pushed (transition "fill done"). There is no transition back out of `RN_RUN`, except through reset.

Top module: `rename_map_unit`

## Requirements
- R1: After reset, `ren_ready` stays low for `NUM_PHYS-NUM_ARCH` cycles (state `RN_FILL`) and then goes high. At that point, architectural name `i` resolves to physical tag `i`.
- R2: For an accepted request, `ren_tag_a` and `ren_tag_b` equal the current binding of `ren_src_a` and `ren_src_b`, in the same cycle.
- R3: For an accepted request with `ren_has_dst=1`, `ren_new_tag` is the oldest tag in the pool. Starting from reset, successive destinations receive `NUM_ARCH`, `NUM_ARCH+1`, and so on, in order.
- R4: For an accepted request with a destination, `ren_old_tag` is the binding the destination name held before this request.
- R5: When a source name equals the destination name, that source receives the old binding, not the newly allocated tag.
- R6: After an accepted request with a destination, a later lookup of that name returns the newly allocated tag, starting from the next cycle.
- R7: An accepted request with `ren_has_dst=0` takes no tag from the pool. The next destination receives the tag it would otherwise have received.
- R8: When the pool is empty, a request with a destination sees `ren_ready=0` and changes no binding. A request without a destination still sees `ren_ready=1`.
- R9: A tag released through `rel_valid`/`rel_tag` in state `RN_RUN` joins the tail of the pool. It is handed out only after every tag already in the pool.
- R10: An allocation and a release in the same cycle are both performed. The pool size is unchanged, and the released tag is queued.
- R11: Releases presented during `RN_FILL` are ignored. The pool then holds exactly the `NUM_PHYS-NUM_ARCH` initial tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request present |
| ren_src_a | input | ARCH_W | First source name |
| ren_src_b | input | ARCH_W | Second source name |
| ren_has_dst | input | 1 | Request writes a destination |
| ren_dst | input | ARCH_W | Destination name |
| ren_ready | output | 1 | Request can be accepted this cycle |
| ren_tag_a | output | TAG_W | Physical tag of first source |
| ren_tag_b | output | TAG_W | Physical tag of second source |
| ren_new_tag | output | TAG_W | Tag allocated to the destination |
| ren_old_tag | output | TAG_W | Previous binding of the destination |
| rel_valid | input | 1 | Release a tag to the pool |
| rel_tag | input | TAG_W | Tag being released |

## Verification
Lookup results, the allocated tag, the old tag and `ren_ready` all depend combinationally on registered state and the current request. They are due in the cycle of the request itself. The bench drives each request on the falling clock edge and samples one time unit later, well before the next rising edge.

A rebinding becomes visible to lookups one cycle after its accepting edge. A released tag enters the pool at its release edge. Both are therefore checked by a later request. The expected values come from a bench model that applies the same update at that rising edge.

// File: rtl/rename_pkg.sv
package rename_pkg;

    typedef enum logic {
        RN_FILL = 1'b0,
        RN_RUN  = 1'b1
    } rn_state_e;

endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl
    import rename_pkg::*;
#(
    parameter int NUM_ARCH = 4,
    parameter int NUM_FREE = 4,
    parameter int TAG_W    = 3,
    localparam int FC_W    = (NUM_FREE > 1) ? $clog2(NUM_FREE) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ren_valid,
    input  logic             ren_has_dst,
    input  logic             pool_empty,
    output logic             ren_ready,
    output logic             alloc_pop,
    output logic             filling,
    output logic [TAG_W-1:0] fill_tag
);

    localparam logic [FC_W-1:0] FILL_LAST = FC_W'(NUM_FREE - 1);

    rn_state_e        state_q, state_d;
    logic [FC_W-1:0]  fill_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= RN_FILL;
            fill_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == RN_FILL) begin
                fill_cnt_q <= fill_cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RN_FILL: if (fill_cnt_q == FILL_LAST) state_d = RN_RUN;
            RN_RUN:  state_d = RN_RUN;
            default: state_d = RN_FILL;
        endcase
    end

    always_comb begin
        filling   = (state_q == RN_FILL);
        fill_tag  = TAG_W'(NUM_ARCH) + TAG_W'(fill_cnt_q);
        ren_ready = (state_q == RN_RUN) && (!ren_has_dst || !pool_empty);
        alloc_pop = ren_valid && ren_ready && ren_has_dst;
    end

endmodule

// File: rtl/rename_free_list.sv
module rename_free_list #(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 3,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    input  logic             pop,
    output logic [TAG_W-1:0] head_tag,
    output logic             empty,
    output logic [CNT_W-1:0] count
);

    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [TAG_W-1:0] slots_q [DEPTH];
    logic [PTR_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (push) begin
            slots_q[tail_q] <= push_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) tail_q <= (tail_q == PTR_LAST) ? '0 : tail_q + 1'b1;
            if (pop)  head_q <= (head_q == PTR_LAST) ? '0 : head_q + 1'b1;
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head_tag = slots_q[head_q];
    assign empty    = (cnt_q == '0);
    assign count    = cnt_q;

endmodule

// File: rtl/rename_map_table.sv
module rename_map_table #(
    parameter int NUM_ARCH = 4,
    parameter int TAG_W    = 3,
    localparam int ARCH_W  = (NUM_ARCH > 1) ? $clog2(NUM_ARCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ARCH_W-1:0] rd_a_idx,
    input  logic [ARCH_W-1:0] rd_b_idx,
    input  logic [ARCH_W-1:0] rd_d_idx,
    output logic [TAG_W-1:0]  rd_a_tag,
    output logic [TAG_W-1:0]  rd_b_tag,
    output logic [TAG_W-1:0]  rd_d_tag,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag
);

    logic [NUM_ARCH-1:0][TAG_W-1:0] bind_q;

    for (genvar i = 0; i < NUM_ARCH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bind_q[i] <= TAG_W'(i);
            end else if (wr_en && (rd_d_idx == ARCH_W'(i))) begin
                bind_q[i] <= wr_tag;
            end
        end
    end

    assign rd_a_tag = bind_q[rd_a_idx];
    assign rd_b_tag = bind_q[rd_b_idx];
    assign rd_d_tag = bind_q[rd_d_idx];

endmodule

// File: rtl/rename_map_unit.sv
module rename_map_unit #(
    parameter int NUM_ARCH = 4,
    parameter int NUM_PHYS = 8,
    localparam int ARCH_W  = (NUM_ARCH > 1) ? $clog2(NUM_ARCH) : 1,
    localparam int TAG_W   = $clog2(NUM_PHYS),
    localparam int CNT_W   = $clog2(NUM_PHYS + 1),
    localparam int NUM_FREE = NUM_PHYS - NUM_ARCH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_valid,
    input  logic [ARCH_W-1:0] ren_src_a,
    input  logic [ARCH_W-1:0] ren_src_b,
    input  logic              ren_has_dst,
    input  logic [ARCH_W-1:0] ren_dst,
    output logic              ren_ready,
    output logic [TAG_W-1:0]  ren_tag_a,
    output logic [TAG_W-1:0]  ren_tag_b,
    output logic [TAG_W-1:0]  ren_new_tag,
    output logic [TAG_W-1:0]  ren_old_tag,
    input  logic              rel_valid,
    input  logic [TAG_W-1:0]  rel_tag
);

    logic             alloc_pop;
    logic             filling;
    logic [TAG_W-1:0] fill_tag;
    logic             pool_empty;
    logic [CNT_W-1:0] fl_count;
    logic             pool_push;
    logic [TAG_W-1:0] pool_push_tag;

    rename_ctrl #(
        .NUM_ARCH (NUM_ARCH),
        .NUM_FREE (NUM_FREE),
        .TAG_W    (TAG_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ren_valid   (ren_valid),
        .ren_has_dst (ren_has_dst),
        .pool_empty  (pool_empty),
        .ren_ready   (ren_ready),
        .alloc_pop   (alloc_pop),
        .filling     (filling),
        .fill_tag    (fill_tag)
    );

    // Initial tags are loaded while filling; releases are only taken after.
    assign pool_push     = filling | rel_valid;
    assign pool_push_tag = filling ? fill_tag : rel_tag;

    rename_free_list #(
        .DEPTH (NUM_PHYS),
        .TAG_W (TAG_W)
    ) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (pool_push),
        .push_tag (pool_push_tag),
        .pop      (alloc_pop),
        .head_tag (ren_new_tag),
        .empty    (pool_empty),
        .count    (fl_count)
    );

    // Reads see the table before this cycle's write lands.
    rename_map_table #(
        .NUM_ARCH (NUM_ARCH),
        .TAG_W    (TAG_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (ren_src_a),
        .rd_b_idx (ren_src_b),
        .rd_d_idx (ren_dst),
        .rd_a_tag (ren_tag_a),
        .rd_b_tag (ren_tag_b),
        .rd_d_tag (ren_old_tag),
        .wr_en    (alloc_pop),
        .wr_tag   (ren_new_tag)
    );

endmodule

// File: rtl/rename_checks.sv
module rename_checks #(
    parameter int NUM_PHYS = 8,
    parameter int TAG_W    = 3,
    parameter int CNT_W    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ren_valid,
    input logic             ren_has_dst,
    input logic             ren_ready,
    input logic [TAG_W-1:0] ren_new_tag,
    input logic [TAG_W-1:0] ren_old_tag,
    input logic             rel_valid,
    input logic             filling,
    input logic [CNT_W-1:0] fl_count
);

    p_fill_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        filling |-> !ren_ready);

    p_distinct_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_ready && ren_has_dst) |-> (ren_new_tag != ren_old_tag));

    p_no_dst_keeps_pool_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!filling && ren_valid && !ren_has_dst && !rel_valid) |=> $stable(fl_count));

    p_stall_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_count == '0 && ren_has_dst) |-> !ren_ready);

    p_pool_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fl_count <= CNT_W'(NUM_PHYS));

    p_swap_keeps_size_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!filling && ren_valid && ren_ready && ren_has_dst && rel_valid) |=> $stable(fl_count));

endmodule

bind rename_map_unit rename_checks #(
    .NUM_PHYS (NUM_PHYS),
    .TAG_W    (TAG_W),
    .CNT_W    (CNT_W)
) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .ren_valid   (ren_valid),
    .ren_has_dst (ren_has_dst),
    .ren_ready   (ren_ready),
    .ren_new_tag (ren_new_tag),
    .ren_old_tag (ren_old_tag),
    .rel_valid   (rel_valid),
    .filling     (filling),
    .fl_count    (fl_count)
);

// File: tb/rename_map_unit_tb.sv
module rename_map_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NA = 4;
    localparam int NP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ren_valid = 1'b0;
    logic [1:0] ren_src_a = '0;
    logic [1:0] ren_src_b = '0;
    logic       ren_has_dst = 1'b0;
    logic [1:0] ren_dst = '0;
    logic       ren_ready;
    logic [2:0] ren_tag_a, ren_tag_b, ren_new_tag, ren_old_tag;
    logic       rel_valid = 1'b0;
    logic [2:0] rel_tag = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    int m_map [NA];
    int m_pool [NP];
    int m_head, m_tail, m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    rename_map_unit #(.NUM_ARCH(NA), .NUM_PHYS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid),
        .ren_src_a(ren_src_a), .ren_src_b(ren_src_b),
        .ren_has_dst(ren_has_dst), .ren_dst(ren_dst),
        .ren_ready(ren_ready), .ren_tag_a(ren_tag_a), .ren_tag_b(ren_tag_b),
        .ren_new_tag(ren_new_tag), .ren_old_tag(ren_old_tag),
        .rel_valid(rel_valid), .rel_tag(rel_tag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_push(input int tag);
        m_pool[m_tail] = tag;
        m_tail = (m_tail + 1) % NP;
        m_cnt++;
    endtask

    // One cycle of stimulus; checks outputs mid-cycle, then updates the model at the edge.
    task automatic step(input string req, input bit v, input int a, input int b,
                        input bit has, input int d, input bit rv, input int rt);
        bit exp_ready, fire;
        int new_tag;
        @(negedge clk);
        ren_valid = v; ren_src_a = 2'(a); ren_src_b = 2'(b);
        ren_has_dst = has; ren_dst = 2'(d);
        rel_valid = rv; rel_tag = 3'(rt);
        #1;
        exp_ready = !has || (m_cnt > 0);
        fire = v && exp_ready;
        if (v) chk(req, "ready", int'(ren_ready), int'(exp_ready));
        if (fire) begin
            chk(req, "tag_a", int'(ren_tag_a), m_map[a]);
            chk(req, "tag_b", int'(ren_tag_b), m_map[b]);
            if (has) begin
                chk(req, "new_tag", int'(ren_new_tag), m_pool[m_head]);
                chk(req, "old_tag", int'(ren_old_tag), m_map[d]);
            end
        end
        @(posedge clk);
        if (fire && has) begin
            new_tag = m_pool[m_head];
            m_map[d] = new_tag;
            m_head = (m_head + 1) % NP;
            m_cnt--;
        end
        if (rv) model_push(rt);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NA; i++) m_map[i] = i;
        m_head = 0; m_tail = 0; m_cnt = 0;
        for (int t = NA; t < NP; t++) model_push(t);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: a release during filling must be ignored
        rel_valid = 1'b1; rel_tag = 3'd2;
        ren_valid = 1'b1; ren_has_dst = 1'b0;
        for (int k = 0; k < NP - NA; k++) begin
            #1;
            chk("R1", "ready during fill", int'(ren_ready), 0);
            @(negedge clk);
        end
        rel_valid = 1'b0;
        #1;
        chk("R1", "ready after fill", int'(ren_ready), 1);

        // R1 / R2: sweep all source pairs with no destination
        for (int a = 0; a < NA; a++)
            for (int b = 0; b < NA; b++)
                step("R2", 1, a, b, 0, 0, 0, 0);

        // R3 / R4 / R6 / R5: four allocations in order
        step("R3", 1, 2, 3, 1, 1, 0, 0);
        step("R6", 1, 2, 1, 1, 3, 0, 0);
        step("R5", 1, 3, 3, 1, 3, 0, 0);
        step("R5", 1, 1, 0, 1, 1, 0, 0);

        // R8 / R11: pool empty now (stale release not queued)
        step("R8", 1, 1, 1, 1, 1, 0, 0);
        step("R8", 1, 1, 3, 0, 0, 0, 0);

        // R9: release two tags, then a no-destination request (R7)
        step("R9", 0, 0, 0, 0, 0, 1, 1);
        step("R9", 0, 0, 0, 0, 0, 1, 3);
        step("R7", 1, 2, 0, 0, 0, 0, 0);

        // R10: allocate and release together
        step("R10", 1, 2, 2, 1, 2, 1, 5);
        step("R10", 1, 2, 0, 1, 0, 0, 0);
        step("R9", 1, 0, 2, 1, 0, 0, 0);
        step("R8", 1, 0, 0, 1, 2, 0, 0);
        step("R8", 1, 2, 0, 0, 0, 0, 0);

        // R9: refill and drain in release order
        step("R9", 0, 0, 0, 0, 0, 1, 4);
        step("R9", 0, 0, 0, 0, 0, 1, 6);
        step("R9", 1, 1, 3, 1, 3, 0, 0);
        step("R9", 1, 3, 1, 1, 1, 0, 0);
        step("R9", 1, 0, 1, 0, 0, 0, 0);

        @(negedge clk);
        ren_valid = 1'b0;
        done = 1'b1;
        summary();
        $finish;
    end

endmodule